// File: doc/BRIEF.md
# Receive Byte Queue with Level and Idle Ready Flag

This block sits between a serial receiver and the register interface a processor reads. Every byte the receiver assembles arrives on a one-cycle write strobe, together with its parity, framing and overrun qualifiers. A byte that arrives clean is appended to a 16-entry queue whose entries are 9 bits wide, so a multiprocessor address bit can travel with the data. The processor drains the queue one entry per read strobe. The head entry is always visible on the read data port.

A data-ready flag tells the processor when a batch is worth collecting. The flag is raised when the stored byte count reaches a programmable level. It is also raised when idle detection is armed, the queue holds a few bytes below that level, and the receive line has stayed quiet for more than eight baud ticks. A processor read restarts the idle count. A byte that arrives with any error shuts the queue off instead of being stored. The queue can only be flushed while it is shut off. When the queue is full, a clean byte is dropped and a one-cycle overflow pulse is returned to the receiver.

Top module: `rxq_buffer`

## Requirements
- R1: The ready flag reads 1 in the same cycle that the fill level first reaches the programmed level; the flag and the new fill level appear together one clock after the write strobe.
- R2: A programmed level of 0 behaves exactly as a level of 1.
- R3: Idle detection applies while it is armed, `rx_idle` is 1 and the fill level is between 1 and the effective level minus 1. Under those conditions, the ninth consecutive baud tick sets the ready flag, and the eighth does not.
- R4: The idle count returns to zero in any cycle that has a read, a stored write, a flush, or a loss of the idle conditions. A read part-way through the count therefore needs nine new ticks before the flag sets.
- R5: Once set, the ready flag stays at 1 while bytes remain, even when the fill drops below the level. It clears in the cycle the fill level becomes 0.
- R6: A write strobe with a parity, framing or overrun qualifier stores nothing and leaves the fill level unchanged. It also clears `q_enabled` one clock later.
- R7: While `q_enabled` is 0, write strobes store nothing and raise no overflow pulse.
- R8: A clean write while enabled and with 16 bytes stored is dropped. `ovf_pulse` is then 1 for exactly the following cycle. The fill level never exceeds 16.
- R9: `cpu_data` shows the oldest stored byte, and shows 0 when the queue is empty. A read strobe on an empty queue changes nothing.
- R10: A flush clears all stored bytes and the ready flag only while `q_enabled` is 0. A flush while enabled is ignored.
- R11: After reset, the fill level is 0, the ready flag is 0, `q_enabled` is 0, `ovf_pulse` is 0 and `cpu_data` is 0.
- R12: `q_en_set` sets the enable and `q_en_clr` clears it, one clock later. An erroneous write strobe in the same cycle wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_en_set | input | 1 | Pulse: enable the queue |
| q_en_clr | input | 1 | Pulse: disable the queue |
| q_flush | input | 1 | Pulse: empty the queue (honoured only while disabled) |
| level_thr | input | 5 | Byte count that raises the ready flag (0 acts as 1) |
| idle_arm | input | 1 | Enables the idle timeout |
| rx_idle | input | 1 | Receiver reports the line idle |
| baud_tick | input | 1 | One pulse per baud bit time |
| rx_valid | input | 1 | Write strobe from the receiver |
| rx_byte | input | 9 | Received character including the address bit |
| rx_par_err | input | 1 | Parity error on this character |
| rx_frm_err | input | 1 | Framing error on this character |
| rx_ovr_err | input | 1 | Overrun error on this character |
| cpu_rd | input | 1 | Processor read strobe, pops the head entry |
| cpu_data | output | 9 | Head entry of the queue |
| data_ready | output | 1 | Level-or-idle ready flag |
| fill_level | output | 5 | Number of stored bytes |
| q_enabled | output | 1 | Current queue enable state |
| ovf_pulse | output | 1 | One-cycle pulse on a dropped write to a full queue |

## Verification
The assertions take it that `rx_valid`, `baud_tick`, the enable pulses and `cpu_rd` are strobes sampled on single clock edges. They also take it that error qualifiers carry meaning only alongside `rx_valid`, and that `level_thr` is held steady while the fill level is compared against it. The stimulus raises every strobe for exactly one cycle and keeps the qualifiers low outside a write. It changes `level_thr` only while the queue is empty. It keeps `rx_idle` high through the timeout scenarios, so that the only things restarting the idle count are the reads and writes the scenario intends.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Width of one stored character: 8 data bits plus the address bit.
    localparam int unsigned RXQ_DW = 9;

    // Receiver write strobe with its error qualifiers.
    typedef struct packed {
        logic valid;
        logic par;
        logic frm;
        logic ovr;
    } rxq_in_t;

    // Qualified queue operation for one cycle.
    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } rxq_op_t;

    function automatic logic rxq_bad(input rxq_in_t w);
        return w.par | w.frm | w.ovr;
    endfunction

    // A level of zero is promoted to one so an empty queue never reports ready.
    function automatic logic [31:0] rxq_eff_level(input logic [31:0] lvl);
        return (lvl == 32'd0) ? 32'd1 : lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  rxq_op_t           op,
    input  logic [RXQ_DW-1:0] wdata,
    output logic [RXQ_DW-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nx
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit          POW2  = (DEPTH == (1 << PTR_W));

    logic [RXQ_DW-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [PTR_W-1:0]  wr_ptr_inc, rd_ptr_inc;

    // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
    generate
        if (POW2) begin : g_wrap_nat
            assign wr_ptr_inc = wr_ptr + 1'b1;
            assign rd_ptr_inc = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_ptr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_comb begin
        if (op.flush) begin
            count_nx = '0;
        end else begin
            count_nx = count + CNT_W'(op.push) - CNT_W'(op.pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nx;
            if (op.flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (op.push) wr_ptr <= wr_ptr_inc;
                if (op.pop)  rd_ptr <= rd_ptr_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (op.push) mem[wr_ptr] <= wdata;
    end

    assign head = (count != '0) ? mem[rd_ptr] : '0;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8
    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        op.push |-> (count != CNT_W'(DEPTH))); // R8
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        op.pop |-> (count != '0)); // R9

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  rxq_in_t          wr,
    input  logic             rd_req,
    input  logic             flush_req,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] count,
    output rxq_op_t          op,
    output logic             en_q,
    output logic             ovf_q
);
    logic full, bad, clean_wr, drop;

    assign full     = (count == CNT_W'(DEPTH));
    assign bad      = wr.valid & rxq_bad(wr);
    assign clean_wr = wr.valid & ~rxq_bad(wr) & en_q;
    assign drop     = clean_wr & full;

    always_comb begin
        op.flush = flush_req & ~en_q;
        op.push  = ~op.flush & clean_wr & ~full;
        op.pop   = ~op.flush & rd_req & (count != '0);
    end

    // Error beats both software pulses; clear beats set.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= drop;
            if (bad || en_clr) begin
                en_q <= 1'b0;
            end else if (en_set) begin
                en_q <= 1'b1;
            end
        end
    end

    AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (rst)
        bad |=> !en_q); // R6
    AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> ($past(count) == CNT_W'(DEPTH))); // R8
    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ovf_q && !$past(drop, 2) |=> !ovf_q || $past(wr.valid)); // R8
    AST_DISABLED_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !op.push); // R7

endmodule

// File: rtl/rxq_ready.sv
module rxq_ready
    import rxq_pkg::*;
#(
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned IDLE_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  rxq_op_t          op,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_nx,
    input  logic [CNT_W-1:0] level,
    input  logic             idle_arm,
    input  logic             rx_idle,
    input  logic             baud_tick,
    output logic             ready
);
    localparam int unsigned TW = $clog2(IDLE_TICKS + 1);

    logic [CNT_W-1:0] lvl_eff;
    logic [TW-1:0]    tick_cnt;
    logic             qual, restart, expire;

    assign lvl_eff = CNT_W'(rxq_eff_level(32'(level)));
    assign qual    = idle_arm & rx_idle & (count != '0) & (count < lvl_eff);
    assign restart = op.push | op.pop | op.flush | ~qual;
    assign expire  = ~restart & baud_tick & (tick_cnt == TW'(IDLE_TICKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (restart || expire) begin
            tick_cnt <= '0;
        end else if (baud_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
        end else if (count_nx == '0) begin
            ready <= 1'b0;
        end else if ((count_nx >= lvl_eff) || expire) begin
            ready <= 1'b1;
        end
    end

    AST_IDLE_BOUND: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= TW'(IDLE_TICKS)); // R3
    AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !ready); // R5
    AST_READ_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        op.pop |=> (tick_cnt == '0)); // R4

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter  int unsigned DEPTH      = 16,
    parameter  int unsigned IDLE_TICKS = 8,
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_en_set,
    input  logic              q_en_clr,
    input  logic              q_flush,
    input  logic [CNT_W-1:0]  level_thr,
    input  logic              idle_arm,
    input  logic              rx_idle,
    input  logic              baud_tick,
    input  logic              rx_valid,
    input  logic [RXQ_DW-1:0] rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_ovr_err,
    input  logic              cpu_rd,
    output logic [RXQ_DW-1:0] cpu_data,
    output logic              data_ready,
    output logic [CNT_W-1:0]  fill_level,
    output logic              q_enabled,
    output logic              ovf_pulse
);
    rxq_in_t          wr;
    rxq_op_t          op;
    logic [CNT_W-1:0] count, count_nx;

    assign wr = '{valid: rx_valid, par: rx_par_err, frm: rx_frm_err, ovr: rx_ovr_err};

    rxq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .rd_req    (cpu_rd),
        .flush_req (q_flush),
        .en_set    (q_en_set),
        .en_clr    (q_en_clr),
        .count     (count),
        .op        (op),
        .en_q      (q_enabled),
        .ovf_q     (ovf_pulse)
    );

    rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (rx_byte),
        .head     (cpu_data),
        .count    (count),
        .count_nx (count_nx)
    );

    rxq_ready #(.CNT_W(CNT_W), .IDLE_TICKS(IDLE_TICKS)) u_ready (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .count     (count),
        .count_nx  (count_nx),
        .level     (level_thr),
        .idle_arm  (idle_arm),
        .rx_idle   (rx_idle),
        .baud_tick (baud_tick),
        .ready     (data_ready)
    );

    assign fill_level = count;

    AST_LEVEL_HIT: assert property (@(posedge clk) disable iff (rst)
        (fill_level != '0) && (fill_level >= CNT_W'(rxq_eff_level(32'(level_thr))))
        && !cpu_rd && !q_flush |=> data_ready); // R1
    AST_FLUSH_GUARD: assert property (@(posedge clk) disable iff (rst)
        q_flush && q_enabled && !rx_valid && !cpu_rd |=> $stable(fill_level)); // R10
    AST_ERR_NOSTORE: assert property (@(posedge clk) disable iff (rst)
        rx_valid && (rx_par_err || rx_frm_err || rx_ovr_err) && !cpu_rd && !q_flush
        |=> $stable(fill_level)); // R6

endmodule

// File: tb/rxq_buffer_test.sv
`timescale 1ns/1ps
module rxq_buffer_test;
    localparam int DEPTH = 16;
    localparam int CW    = 5;
    localparam int DW    = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          q_en_set = 0, q_en_clr = 0, q_flush = 0;
    logic [CW-1:0] level_thr = '0;
    logic          idle_arm = 0, rx_idle = 0, baud_tick = 0;
    logic          rx_valid = 0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_par_err = 0, rx_frm_err = 0, rx_ovr_err = 0;
    logic          cpu_rd = 0;
    logic [DW-1:0] cpu_data;
    logic          data_ready;
    logic [CW-1:0] fill_level;
    logic          q_enabled;
    logic          ovf_pulse;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R11";

    always #2.5 clk = ~clk;

    rxq_buffer uut (
        .clk(clk), .rst(rst), .q_en_set(q_en_set), .q_en_clr(q_en_clr),
        .q_flush(q_flush), .level_thr(level_thr), .idle_arm(idle_arm),
        .rx_idle(rx_idle), .baud_tick(baud_tick), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_ovr_err(rx_ovr_err), .cpu_rd(cpu_rd), .cpu_data(cpu_data),
        .data_ready(data_ready), .fill_level(fill_level),
        .q_enabled(q_enabled), .ovf_pulse(ovf_pulse)
    );

    // Behavioural reference model
    logic [DW-1:0] mq[$];
    int m_en = 0, m_ready = 0, m_idle = 0, m_ovf = 0;

    always @(posedge clk) begin : model
        int sz, te, nsz;
        bit err, push, pop, fl, tmo, qual;
        if (rst) begin
            mq.delete();
            m_en = 0; m_ready = 0; m_idle = 0; m_ovf = 0;
        end else begin
            sz   = mq.size();
            te   = (level_thr == 0) ? 1 : int'(level_thr);
            err  = rx_par_err | rx_frm_err | rx_ovr_err;
            fl   = q_flush && (m_en == 0);
            push = !fl && rx_valid && (m_en != 0) && !err && (sz < DEPTH);
            pop  = !fl && cpu_rd && (sz > 0);
            m_ovf = (rx_valid && (m_en != 0) && !err && (sz == DEPTH)) ? 1 : 0;
            qual = idle_arm && rx_idle && (sz > 0) && (sz < te);
            tmo  = 0;
            if (push || pop || fl || !qual) m_idle = 0;
            else if (baud_tick) begin
                if (m_idle == 8) begin tmo = 1; m_idle = 0; end
                else m_idle++;
            end
            if (fl) mq.delete();
            else begin
                if (pop) void'(mq.pop_front());
                if (push) mq.push_back(rx_byte);
            end
            nsz = mq.size();
            if (nsz == 0) m_ready = 0;
            else if (nsz >= te || tmo) m_ready = 1;
            if (rx_valid && err) m_en = 0;
            else if (q_en_clr) m_en = 0;
            else if (q_en_set) m_en = 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("cpu_data",   int'(cpu_data),   (mq.size() > 0) ? int'(mq[0]) : 0);
            chk("data_ready", int'(data_ready), m_ready);
            chk("fill_level", int'(fill_level), mq.size());
            chk("q_enabled",  int'(q_enabled),  m_en);
            chk("ovf_pulse",  int'(ovf_pulse),  m_ovf);
        end
    end

    // Stimulus tasks: each starts and ends just after a falling edge.
    task automatic put(input logic [DW-1:0] d, input bit p, input bit f, input bit o);
        rx_valid = 1; rx_byte = d; rx_par_err = p; rx_frm_err = f; rx_ovr_err = o;
        @(negedge clk);
        rx_valid = 0; rx_par_err = 0; rx_frm_err = 0; rx_ovr_err = 0;
    endtask
    task automatic take();
        cpu_rd = 1; @(negedge clk); cpu_rd = 0;
    endtask
    task automatic tick();
        baud_tick = 1; @(negedge clk); baud_tick = 0; @(negedge clk);
    endtask
    task automatic enable();
        q_en_set = 1; @(negedge clk); q_en_set = 0;
    endtask
    task automatic disable_q();
        q_en_clr = 1; @(negedge clk); q_en_clr = 0;
    endtask
    task automatic flush();
        q_flush = 1; @(negedge clk); q_flush = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tag = "R11";
        chk("reset fill", int'(fill_level), 0);
        chk("reset ready", int'(data_ready), 0);
        chk("reset enable", int'(q_enabled), 0);
        chk("reset data", int'(cpu_data), 0);

        // Enable and level hit
        tag = "R12"; enable();
        chk("enabled", int'(q_enabled), 1);
        tag = "R1"; level_thr = 4;
        put(9'h011, 0, 0, 0); put(9'h1A5, 0, 0, 0); put(9'h022, 0, 0, 0);
        chk("below level", int'(data_ready), 0);
        put(9'h0FF, 0, 0, 0);
        chk("level reached", int'(data_ready), 1);
        tag = "R9";
        chk("head shown", int'(cpu_data), 'h011);
        tag = "R5";
        take(); take();
        chk("sticky ready", int'(data_ready), 1);
        take(); take();
        chk("empty clears", int'(data_ready), 0);
        tag = "R9";
        take();
        chk("empty read", int'(fill_level), 0);

        // Level zero acts as one
        tag = "R2"; level_thr = 0;
        put(9'h155, 0, 0, 0);
        chk("level0", int'(data_ready), 1);
        take();

        // Idle timeout
        tag = "R3"; level_thr = 8; idle_arm = 1; rx_idle = 1;
        put(9'h031, 0, 0, 0); put(9'h132, 0, 0, 0);
        repeat (8) tick();
        chk("eight ticks", int'(data_ready), 0);
        tick();
        chk("ninth tick", int'(data_ready), 1);
        take(); take();

        // Restart by read
        tag = "R4";
        put(9'h041, 0, 0, 0); put(9'h042, 0, 0, 0);
        repeat (5) tick();
        take();
        repeat (8) tick();
        chk("restart eight", int'(data_ready), 0);
        tick();
        chk("restart ninth", int'(data_ready), 1);
        take();
        idle_arm = 0; rx_idle = 0;

        // Full and overflow
        tag = "R8"; level_thr = 16;
        for (int i = 0; i < 16; i++) put(DW'(9'h080 + i), 0, 0, 0);
        chk("full ready", int'(data_ready), 1);
        put(9'h1EE, 0, 0, 0);
        chk("ovf pulse", int'(ovf_pulse), 1);
        chk("full fill", int'(fill_level), 16);
        @(negedge clk);
        chk("ovf ends", int'(ovf_pulse), 0);
        for (int i = 0; i < 16; i++) take();

        // Flush guard and disabled writes
        tag = "R10"; level_thr = 4;
        put(9'h061, 0, 0, 0); put(9'h062, 0, 0, 0); put(9'h063, 0, 0, 0);
        flush();
        chk("flush ignored", int'(fill_level), 3);
        disable_q();
        tag = "R7";
        put(9'h064, 0, 0, 0);
        chk("disabled write", int'(fill_level), 3);
        tag = "R10";
        flush();
        chk("flush done", int'(fill_level), 0);

        // Error disables without storing
        tag = "R6";
        enable(); put(9'h071, 0, 0, 0);
        put(9'h072, 1, 0, 0);
        chk("parity no store", int'(fill_level), 1);
        chk("parity disable", int'(q_enabled), 0);
        enable(); put(9'h073, 0, 1, 0);
        chk("framing disable", int'(q_enabled), 0);
        enable(); put(9'h074, 0, 0, 1);
        chk("overrun disable", int'(q_enabled), 0);
        tag = "R12";
        q_en_set = 1; put(9'h075, 1, 0, 0); q_en_set = 0;
        chk("error beats set", int'(q_enabled), 0);
        take();
        repeat (3) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule